// File: doc/BRIEF.md
# Decimating and Cropping Frame-Store Writer

This block sits between a camera-style raster source and an on-chip frame store. Input pixels are 8 bits and arrive one per clock whenever a valid strobe is high. A start-of-frame flag marks the first pixel of a frame and an end-of-line flag marks the last pixel of each line. The nominal input is 320 pixels by 240 lines. The block halves the picture in both directions by plain subsampling, which gives a 160 by 120 image. From that image it keeps a centred 128 by 96 window. Every kept pixel leaves through a registered write port (enable, address, data) that feeds a 12288-entry memory holding one byte per location.

The window is 128 wide, a power of two, so the write address is just the row field placed above the column field. No multiplier is needed and no row is padded out to a wider power of two. A one-cycle pulse reports that the final window pixel has been written. All geometry is set by parameters, and the crop offsets are derived from them so that the window stays centred.

Top module: `fbdc_writer`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, `wr_en` and `frame_done` are 0.
- R2: Only input pixels on an even column and an even line (both counted from 0) can produce a write. All other pixels are dropped.
- R3: With the default sizes, a pixel is written only if its halved column lies in 16..143 and its halved line lies in 12..107.
- R4: The write address is {y, x}. x (bits 6:0) is the halved column minus 16 and y (bits 13:7) is the halved line minus 12. Numerically this is y*128 + x. The row field is never 96 or above.
- R5: A kept pixel that is accepted on a clock edge appears on `wr_en`, `wr_addr` and `wr_data` right after that edge. `wr_data` equals the input pixel.
- R6: A cycle with `in_valid` low writes nothing and moves no counter, whatever `in_sof`, `in_eol` and `in_pix` carry.
- R7: A valid pixel with `in_eol` high is the last pixel of its line, so the next valid pixel is column 0 of the following line, even when the line is shorter than nominal.
- R8: A valid pixel with `in_sof` high is column 0, line 0, whatever position the counters held before.
- R9: `frame_done` is high for exactly one cycle, the cycle after the write to window position x=127, y=95. At no other time is it high.
- R10: A well-formed 320x240 frame produces exactly 12288 writes, one to each address 0..12287.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of frame (qualified by in_valid) |
| in_eol | input | 1 | Last pixel of line (qualified by in_valid) |
| in_pix | input | 8 | Input pixel value |
| wr_en | output | 1 | Frame-store write enable |
| wr_addr | output | 14 | Frame-store address {row, column} |
| wr_data | output | 8 | Frame-store write data |
| frame_done | output | 1 | One-cycle pulse after the last window pixel is written |

## Verification
The bench goes after the edges of the window. An off-by-one in the crop compare would write column 144 or line 108. The full-frame count and the per-address once-only tally would then expose it as a 12289th write or a duplicated address. Odd-phase pixels leaking through would alias two inputs onto one address. A design that let `in_sof` or `in_eol` act while `in_valid` is low would shift every later address of the frame. A design that ignored a mid-line restart or an early end-of-line would place the following lines at wrong rows, and `frame_done` would then fire on a frame that never reaches the last window corner, or fail to fire on one that does.

// File: rtl/fbdc_pkg.sv
package fbdc_pkg;
  localparam int PIX_W_DEF  = 8;
  localparam int IN_W_DEF   = 320;
  localparam int IN_H_DEF   = 240;
  localparam int DEC_LG_DEF = 1;
  localparam int WIN_W_DEF  = 128;
  localparam int WIN_H_DEF  = 96;

  // centred offset of a window inside a decimated span
  function automatic int centre_off(int span, int dec_lg, int win);
    return ((span >> dec_lg) - win) / 2;
  endfunction
endpackage

// File: rtl/fbdc_coord_cnt.sv
module fbdc_coord_cnt #(
  parameter int CW = 9,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          sof,
  input  logic          eol,
  output logic [CW-1:0] cur_col,
  output logic [RW-1:0] cur_row
);
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;

  // a start-of-frame pixel sits at the origin regardless of history
  assign cur_col = sof ? '0 : col_q;
  assign cur_row = sof ? '0 : row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid) begin
      if (eol) begin
        col_q <= '0;
        row_q <= (cur_row != '1) ? cur_row + RW'(1) : cur_row;
      end else begin
        col_q <= (cur_col != '1) ? cur_col + CW'(1) : cur_col;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/fbdc_window.sv
module fbdc_window #(
  parameter int CW     = 9,
  parameter int RW     = 8,
  parameter int DEC_LG = 1,
  parameter int X_OFF  = 16,
  parameter int Y_OFF  = 12,
  parameter int WIN_W  = 128,
  parameter int WIN_H  = 96,
  parameter int XW     = 7,
  parameter int YW     = 7
) (
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  output logic          hit,
  output logic          corner,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);
  logic [CW-1:0] dx;
  logic [RW-1:0] dy;
  logic          phase_ok;
  logic          in_x, in_y;

  generate
    if (DEC_LG == 0) begin : g_nodec
      assign dx       = col;
      assign dy       = row;
      assign phase_ok = 1'b1;
    end else begin : g_dec
      assign dx       = col >> DEC_LG;
      assign dy       = row >> DEC_LG;
      assign phase_ok = (col[DEC_LG-1:0] == '0) && (row[DEC_LG-1:0] == '0);
    end
  endgenerate

  assign in_x = (dx >= CW'(X_OFF)) && (dx < CW'(X_OFF + WIN_W));
  assign in_y = (dy >= RW'(Y_OFF)) && (dy < RW'(Y_OFF + WIN_H));
  assign hit  = phase_ok && in_x && in_y;

  assign x = XW'(dx - CW'(X_OFF));
  assign y = YW'(dy - RW'(Y_OFF));

  assign corner = hit && (x == XW'(WIN_W - 1)) && (y == YW'(WIN_H - 1));
endmodule

// File: rtl/fbdc_writer.sv
module fbdc_writer #(
  parameter int PIX_W  = fbdc_pkg::PIX_W_DEF,
  parameter int IN_W   = fbdc_pkg::IN_W_DEF,
  parameter int IN_H   = fbdc_pkg::IN_H_DEF,
  parameter int DEC_LG = fbdc_pkg::DEC_LG_DEF,
  parameter int WIN_W  = fbdc_pkg::WIN_W_DEF,
  parameter int WIN_H  = fbdc_pkg::WIN_H_DEF,
  localparam int CW    = $clog2(IN_W),
  localparam int RW    = $clog2(IN_H),
  localparam int XW    = $clog2(WIN_W),
  localparam int YW    = $clog2(WIN_H),
  localparam int AW    = XW + YW,
  localparam int X_OFF = fbdc_pkg::centre_off(IN_W, DEC_LG, WIN_W),
  localparam int Y_OFF = fbdc_pkg::centre_off(IN_H, DEC_LG, WIN_H)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  output logic             frame_done
);
  logic [CW-1:0] cur_col;
  logic [RW-1:0] cur_row;
  logic          hit, corner;
  logic [XW-1:0] wx;
  logic [YW-1:0] wy;
  logic          last_q;

  fbdc_coord_cnt #(.CW(CW), .RW(RW)) cnt_i (
    .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .eol(in_eol),
    .cur_col(cur_col), .cur_row(cur_row)
  );

  fbdc_window #(
    .CW(CW), .RW(RW), .DEC_LG(DEC_LG), .X_OFF(X_OFF), .Y_OFF(Y_OFF),
    .WIN_W(WIN_W), .WIN_H(WIN_H), .XW(XW), .YW(YW)
  ) win_i (
    .col(cur_col), .row(cur_row), .hit(hit), .corner(corner), .x(wx), .y(wy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      last_q     <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      wr_en      <= in_valid && hit;
      last_q     <= in_valid && corner;
      frame_done <= last_q;
    end
  end

  // address and data need no reset: they only matter while wr_en is high
  always_ff @(posedge clk) begin
    wr_addr <= {wy, wx};
    wr_data <= in_pix;
  end
endmodule

// File: rtl/fbdc_writer_chk.sv
module fbdc_writer_chk #(
  parameter int PIX_W = 8,
  parameter int XW    = 7,
  parameter int YW    = 7,
  parameter int WIN_W = 128,
  parameter int WIN_H = 96
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pix,
  input logic             wr_en,
  input logic [XW+YW-1:0] wr_addr,
  input logic [PIX_W-1:0] wr_data,
  input logic             frame_done
);
  localparam logic [XW+YW-1:0] CORNER = {YW'(WIN_H - 1), XW'(WIN_W - 1)};

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wr_en && !frame_done));

  p_row_field_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr[XW+YW-1:XW]) < WIN_H));

  p_data_follows_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(in_valid) && (wr_data == $past(in_pix))));

  p_idle_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wr_en);

  p_done_after_corner_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(wr_en) && ($past(wr_addr) == CORNER)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

bind fbdc_writer fbdc_writer_chk #(
  .PIX_W(PIX_W), .XW(XW), .YW(YW), .WIN_W(WIN_W), .WIN_H(WIN_H)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
);

// File: tb/fbdc_writer_tb_top.sv
`timescale 1ns/1ps
module fbdc_writer_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic [1:0] vld, sof, eol;
  logic [7:0] pix0, pix1;
  logic       en0, en1, dn0, dn1;
  logic [13:0] a0;
  logic [4:0]  a1;
  logic [7:0]  d0, d1;

  fbdc_writer dut_i (
    .clk(clk), .rst(rst), .in_valid(vld[0]), .in_sof(sof[0]), .in_eol(eol[0]),
    .in_pix(pix0), .wr_en(en0), .wr_addr(a0), .wr_data(d0), .frame_done(dn0)
  );

  // small configuration: 20x16 in, 10x8 halved, 8x4 window at offset (1,2)
  fbdc_writer #(.IN_W(20), .IN_H(16), .WIN_W(8), .WIN_H(4)) dut_s (
    .clk(clk), .rst(rst), .in_valid(vld[1]), .in_sof(sof[1]), .in_eol(eol[1]),
    .in_pix(pix1), .wr_en(en1), .wr_addr(a1), .wr_data(d1), .frame_done(dn1)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt, dn_cnt;
  int seen [16384];
  bit e_en = 0, e_last = 0, e_done = 0, e_v = 0;
  int e_addr = 0;
  logic [7:0] e_data = '0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(bit sel, bit v, bit s, bit e, logic [7:0] p, int r, int c);
    int xo, yo, ww, wh, dx, dy, aad, ada;
    bit k, aen, adn;
    @(negedge clk);
    aen = sel ? en1 : en0;
    adn = sel ? dn1 : dn0;
    aad = sel ? int'(a1) : int'(a0);
    ada = sel ? int'(d1) : int'(d0);
    chk(aen == e_en, e_v ? "R2/R3 write enable" : "R6 write enable", aen, e_en);
    if (e_en) begin
      chk(aad == e_addr, "R4 address", aad, e_addr);
      chk(ada == int'(e_data), "R5 data", ada, e_data);
    end
    chk(adn == e_done, "R9 frame_done", adn, e_done);
    if (aen) begin
      wr_cnt++;
      if (!sel && aad < 16384) seen[aad]++;
    end
    if (adn) dn_cnt++;
    e_done = e_last;
    vld = '0; sof = '0; eol = '0;
    vld[sel] = v; sof[sel] = s; eol[sel] = e;
    if (sel) pix1 = p; else pix0 = p;
    xo = sel ? 1 : 16;  yo = sel ? 2 : 12;
    ww = sel ? 8 : 128; wh = sel ? 4 : 96;
    dx = c / 2; dy = r / 2;
    k = v && (c % 2 == 0) && (r % 2 == 0) && dx >= xo && dx < xo + ww
        && dy >= yo && dy < yo + wh;
    e_en   = k;
    e_addr = (dy - yo) * ww + (dx - xo);
    e_data = p;
    e_last = k && (dx - xo == ww - 1) && (dy - yo == wh - 1);
    e_v    = v;
  endtask

  task automatic frame(bit sel, int len, int lines, int gap, int limit, int seed);
    int n = 0;
    for (int r = 0; r < lines; r++) begin
      for (int c = 0; c < len; c++) begin
        if (limit > 0 && n >= limit) return;
        if (gap > 0 && (n % gap) == gap - 1)
          tick(sel, 1'b0, 1'b1, 1'b1, 8'hA5, 0, 0);   // noise while invalid
        tick(sel, 1'b1, (r == 0 && c == 0), (c == len - 1),
             8'(r * 31 + c * 7 + seed), r, c);
        n++;
      end
    end
  endtask

  task automatic flush(bit sel);
    repeat (3) tick(sel, 1'b0, 1'b0, 1'b0, 8'h00, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int bad;
    rst = 1'b1; vld = '0; sof = '0; eol = '0; pix0 = '0; pix1 = '0;
    repeat (3) @(negedge clk);
    chk(!en0 && !dn0, "R1 reset outputs (default)", {en0, dn0}, 0);
    chk(!en1 && !dn1, "R1 reset outputs (small)", {en1, dn1}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R10: full default frame, contiguous
    wr_cnt = 0; dn_cnt = 0;
    for (int i = 0; i < 16384; i++) seen[i] = 0;
    frame(1'b0, 320, 240, 0, 0, 5);
    flush(1'b0);
    chk(wr_cnt == 12288, "R10 write count", wr_cnt, 12288);
    chk(dn_cnt == 1, "R9 done pulses per frame", dn_cnt, 1);
    bad = 0;
    for (int i = 0; i < 16384; i++)
      if (seen[i] != ((i < 12288) ? 1 : 0)) bad++;
    chk(bad == 0, "R10 each location written once", bad, 0);

    // R6: small frame with idle noise cycles
    wr_cnt = 0; dn_cnt = 0;
    frame(1'b1, 20, 16, 3, 0, 11);
    flush(1'b1);
    chk(wr_cnt == 32, "R6 writes with gaps", wr_cnt, 32);
    chk(dn_cnt == 1, "R6 done with gaps", dn_cnt, 1);

    // R8: frame aborted mid-line, then restarted by sof
    wr_cnt = 0; dn_cnt = 0;
    frame(1'b1, 20, 16, 0, 165, 3);
    frame(1'b1, 20, 16, 0, 0, 9);
    flush(1'b1);
    chk(wr_cnt == 50, "R8 writes across restart", wr_cnt, 50);
    chk(dn_cnt == 1, "R8 done across restart", dn_cnt, 1);

    // R7: short lines ended early by eol
    wr_cnt = 0; dn_cnt = 0;
    frame(1'b1, 14, 16, 0, 0, 21);
    flush(1'b1);
    chk(wr_cnt == 24, "R7 writes with short lines", wr_cnt, 24);
    chk(dn_cnt == 0, "R7 no done without corner", dn_cnt, 0);

    summary();
    $finish;
  end
endmodule